// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the message-signalled-interrupt capability of a PCI function. It sits on the function's configuration-space access port, which carries a dword address, four byte enables and 32 bits of write data. It claims only the dwords of its own capability window. Inside that window it keeps the control word, the message address, the message data and, when masking is configured, the per-vector mask and pending registers. Every write is merged through a per-field write mask, so read-only and reserved bits never change.

Three build-time parameters shape the structure: the number of vectors the function can use (a power of two from 1 to 32), whether the message address is 64 bits wide, and whether each vector can be masked. These choices set the window length and the register positions. The message generator beside the block reads the live register values from dedicated outputs. It also sets and clears pending bits through two vector inputs. Software can read the pending register but cannot write it.

Top module: `msi_cap_regs`

## Requirements
- R1: A synchronous active-high reset clears the enable bit, the enabled-vector field, the address, the data, the mask and the pending register. The capability flags in the control word keep their build-time values.
- R2: Window dword +0 reads as follows. Byte 0 is the capability ID 0x05 and byte 1 is zero. Bits [31:16] hold the control word: bit 0 is enable (writable), bits [3:1] hold log2 of the vector count (read-only), bits [6:4] hold the enabled-vector field (writable), bit 7 is the 64-bit flag (read-only) and bit 8 is the mask flag (read-only). All other bits read zero.
- R3: Dword +1 is the low message address. Bits [31:2] are writable and bits [1:0] always read zero.
- R4: With 64-bit support, dword +2 is the high message address and all 32 bits are writable. Without it, dword +2 holds the message data.
- R5: The message data is a 16-bit writable field in bits [15:0] of dword +3 (64-bit) or dword +2 (32-bit). Bits [31:16] of that dword read zero.
- R6: With masking, the mask register is at dword +4 (64-bit) or +3 (32-bit). Only bits 0 to vector count − 1 are writable, and every other bit reads zero.
- R7: With masking, the pending register is the next dword after the mask. Software writes leave it unchanged. A bit is cleared by `pend_clr` and set by `pend_set`, and set wins when both arrive in the same cycle. Only bits below the vector count can be set. Without masking, pending always reads zero.
- R8: After any write that lands in the window while the enable bit is 1, an enabled-vector value larger than the capable value is replaced by the capable value. While the enable bit is 0, any value is kept as written.
- R9: The window is 10, 14, 20 or 24 bytes long (32/64-bit, each without or with masking), and so covers 3, 4, 5 or 6 dwords. Writes outside it change nothing, and reads outside it return zero.
- R10: A write changes only the bytes whose byte enable is set.
- R11: `msi_en`, `msg_mme`, `msg_addr`, `msg_data`, `vec_mask` and `vec_pend` show the register values from the clock edge after the write. `cfg_rdata` follows `cfg_addr` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | CFG_AW | Configuration dword address |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pend_set | input | 32 | Pending bits to set (from message generator) |
| pend_clr | input | 32 | Pending bits to clear (from message generator) |
| msi_en | output | 1 | MSI enable bit |
| msg_mme | output | 3 | Enabled-vector field (log2) |
| msg_addr | output | 64 | Message address (upper half zero without 64-bit) |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask |
| vec_pend | output | 32 | Per-vector pending |

## Verification
The bench runs two instances side by side: one with 64-bit addressing and masking, one with 32-bit addressing and no masking. The same write therefore lands on different registers in each. A register map that ignored the 64-bit option would put the data and mask in the wrong dword, and the dword +2 reads would fail.

The clamp is tested from both sides. An oversized value written while the enable bit is 0 must survive. It must then shrink on the next write that enables the block, and on any later window write while enabled. A design that clamped unconditionally, or only on control-word writes, would show the wrong field.

Other directed cases probe single bits and boundaries:
- writes to read-only capability flags and to address bits [1:0];
- mask bits at and above the vector count;
- software writes to the pending register;
- set and clear arriving on the same pending bit;
- the dwords just before and just after the window.

A design that leaked any of these would read back a nonzero value where zero is required, or would lose the set.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam logic [7:0] MSI_CAP_ID = 8'h05;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_HDR,
        SEL_ADLO,
        SEL_ADHI,
        SEL_DATA,
        SEL_MASK,
        SEL_PEND
    } msi_sel_e;

    typedef struct packed {
        logic       en;
        logic [2:0] mme;
    } msi_ctrl_t;

    function automatic int cap_len_bytes(bit a64, bit msk);
        if (msk) return a64 ? 24 : 20;
        return a64 ? 14 : 10;
    endfunction

    function automatic int win_dwords(bit a64, bit msk);
        return (cap_len_bytes(a64, msk) + 3) / 4;
    endfunction

    function automatic int vec_log2(int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    function automatic logic [31:0] vec_bits(int n);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++)
            if (i < n) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] be_merge(logic [31:0] old, logic [31:0] wd,
                                             logic [3:0] be, logic [31:0] wm);
        logic [31:0] r;
        r = old;
        for (int i = 0; i < 4; i++)
            if (be[i])
                r[i*8 +: 8] = (wd[i*8 +: 8] & wm[i*8 +: 8]) |
                              (old[i*8 +: 8] & ~wm[i*8 +: 8]);
        return r;
    endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter int CFG_AW  = 6,
    parameter int CAP_DW  = 20,
    parameter bit ADDR64  = 1'b1,
    parameter bit MASK_EN = 1'b1
) (
    input  logic [CFG_AW-1:0] addr,
    output logic              in_win,
    output msi_sel_e          sel
);
    localparam int WIN_DW = win_dwords(ADDR64, MASK_EN);
    localparam logic [CFG_AW-1:0] BASE = CFG_AW'(CAP_DW);
    localparam logic [CFG_AW-1:0] WIN  = CFG_AW'(WIN_DW);

    logic [CFG_AW-1:0] rel;
    logic [2:0]        slot;

    assign rel    = addr - BASE;
    assign slot   = rel[2:0];
    assign in_win = (addr >= BASE) && (rel < WIN);

    always_comb begin
        sel = SEL_NONE;
        if (in_win) begin
            case (slot)
                3'd0: sel = SEL_HDR;
                3'd1: sel = SEL_ADLO;
                3'd2: sel = ADDR64 ? SEL_ADHI : SEL_DATA;
                3'd3: sel = ADDR64 ? SEL_DATA : (MASK_EN ? SEL_MASK : SEL_NONE);
                3'd4: sel = MASK_EN ? (ADDR64 ? SEL_MASK : SEL_PEND) : SEL_NONE;
                3'd5: sel = (MASK_EN && ADDR64) ? SEL_PEND : SEL_NONE;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
    import msi_cap_pkg::*;
#(
    parameter int VEC_CAP = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_byte,
    output msi_ctrl_t  ctrl_q
);
    localparam logic [2:0] MMC = 3'(vec_log2(VEC_CAP));

    msi_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.en  = ctrl_byte[0];
            ctrl_d.mme = ctrl_byte[6:4];
        end
        if (wr_hit && ctrl_d.en && (ctrl_d.mme > MMC))
            ctrl_d.mme = MMC;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ctrl_q.en && ctrl_q.mme == 3'd0));

    assert_clamp_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> !(ctrl_q.en && ctrl_q.mme > MMC));

    assert_ctrl_outside_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctrl_q));
endmodule

// File: rtl/msi_cap_msgregs.sv
module msi_cap_msgregs
    import msi_cap_pkg::*;
#(
    parameter int VEC_CAP = 8,
    parameter bit ADDR64  = 1'b1,
    parameter bit MASK_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  msi_sel_e    sel,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] pend_set,
    input  logic [31:0] pend_clr,
    output logic [63:0] addr_q,
    output logic [15:0] data_q,
    output logic [31:0] mask_q,
    output logic [31:0] pend_q
);
    localparam logic [31:0] VMSK    = vec_bits(VEC_CAP);
    localparam logic [31:0] LO_WMSK = 32'hFFFF_FFFC;

    logic [31:0] lo_q;
    logic [31:0] data_merged;

    assign data_merged = be_merge({16'h0, data_q}, wdata, be, 32'h0000_FFFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            data_q <= '0;
        end else if (wr) begin
            if (sel == SEL_ADLO) lo_q   <= be_merge(lo_q, wdata, be, LO_WMSK);
            if (sel == SEL_DATA) data_q <= data_merged[15:0];
        end
    end

    generate
        if (ADDR64) begin : g_hi
            logic [31:0] hi_q;
            always_ff @(posedge clk) begin
                if (rst)                         hi_q <= '0;
                else if (wr && sel == SEL_ADHI)  hi_q <= be_merge(hi_q, wdata, be, 32'hFFFF_FFFF);
            end
            assign addr_q = {hi_q, lo_q};
        end else begin : g_nohi
            assign addr_q = {32'h0, lo_q};
        end

        if (MASK_EN) begin : g_mask
            logic [31:0] m_q;
            logic [31:0] p_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    m_q <= '0;
                    p_q <= '0;
                end else begin
                    if (wr && sel == SEL_MASK) m_q <= be_merge(m_q, wdata, be, VMSK);
                    p_q <= ((p_q & ~pend_clr) | pend_set) & VMSK;
                end
            end
            assign mask_q = m_q;
            assign pend_q = p_q;

            assert_mask_width_R6: assert property (@(posedge clk) disable iff (rst)
                (wr && sel == SEL_MASK) |=> ((mask_q & ~VMSK) == 32'h0));

            assert_pend_sw_ro_R7: assert property (@(posedge clk) disable iff (rst)
                (wr && sel == SEL_PEND && pend_set == 32'h0 && pend_clr == 32'h0)
                |=> $stable(pend_q));

            assert_pend_clear_R7: assert property (@(posedge clk) disable iff (rst)
                ((pend_clr & ~pend_set) != 32'h0)
                |=> ((pend_q & $past(pend_clr & ~pend_set)) == 32'h0));
        end else begin : g_nomask
            assign mask_q = '0;
            assign pend_q = '0;
        end
    endgenerate

    assert_addr_lo_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ADLO) |=> (addr_q[1:0] == 2'b00));

    assert_no_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (!ADDR64 && wr) |=> (addr_q[63:32] == 32'h0));

    assert_msg_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_q == 64'h0 && data_q == 16'h0 && mask_q == 32'h0));
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int CFG_AW  = 6,
    parameter int CAP_DW  = 20,
    parameter int VEC_CAP = 8,
    parameter bit ADDR64  = 1'b1,
    parameter bit MASK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       pend_set,
    input  logic [31:0]       pend_clr,
    output logic              msi_en,
    output logic [2:0]        msg_mme,
    output logic [63:0]       msg_addr,
    output logic [15:0]       msg_data,
    output logic [31:0]       vec_mask,
    output logic [31:0]       vec_pend
);
    localparam logic [2:0] MMC = 3'(vec_log2(VEC_CAP));

    logic      in_win;
    msi_sel_e  sel;
    msi_ctrl_t ctrl_q;
    logic [15:0] ctrl_word;

    msi_cap_decode #(
        .CFG_AW (CFG_AW),
        .CAP_DW (CAP_DW),
        .ADDR64 (ADDR64),
        .MASK_EN(MASK_EN)
    ) u_decode (
        .addr  (cfg_addr),
        .in_win(in_win),
        .sel   (sel)
    );

    msi_cap_ctrl #(
        .VEC_CAP(VEC_CAP)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (cfg_wr && in_win),
        .ctrl_wr  (cfg_wr && sel == SEL_HDR && cfg_be[2]),
        .ctrl_byte(cfg_wdata[23:16]),
        .ctrl_q   (ctrl_q)
    );

    msi_cap_msgregs #(
        .VEC_CAP(VEC_CAP),
        .ADDR64 (ADDR64),
        .MASK_EN(MASK_EN)
    ) u_msg (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .sel     (sel),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .pend_set(pend_set),
        .pend_clr(pend_clr),
        .addr_q  (msg_addr),
        .data_q  (msg_data),
        .mask_q  (vec_mask),
        .pend_q  (vec_pend)
    );

    assign msi_en    = ctrl_q.en;
    assign msg_mme   = ctrl_q.mme;
    assign ctrl_word = {7'h0, MASK_EN, ADDR64, ctrl_q.mme, MMC, ctrl_q.en};

    always_comb begin
        case (sel)
            SEL_HDR:  cfg_rdata = {ctrl_word, 8'h00, MSI_CAP_ID};
            SEL_ADLO: cfg_rdata = msg_addr[31:0];
            SEL_ADHI: cfg_rdata = msg_addr[63:32];
            SEL_DATA: cfg_rdata = {16'h0, msg_data};
            SEL_MASK: cfg_rdata = vec_mask;
            SEL_PEND: cfg_rdata = vec_pend;
            default:  cfg_rdata = 32'h0;
        endcase
    end
endmodule

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 6;
    localparam int BASE = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] cfg_addr = '0;
    logic cfg_wr = 1'b0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pend_set = '0;
    logic [31:0] pend_clr = '0;

    logic [31:0] rd0, rd1;
    logic en0, en1;
    logic [2:0] mme0, mme1;
    logic [63:0] ad0, ad1;
    logic [15:0] dt0, dt1;
    logic [31:0] mk0, mk1, pd0, pd1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_cap_regs #(.CFG_AW(AW), .CAP_DW(BASE), .VEC_CAP(8), .ADDR64(1'b1), .MASK_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .pend_set(pend_set), .pend_clr(pend_clr),
        .msi_en(en0), .msg_mme(mme0), .msg_addr(ad0), .msg_data(dt0),
        .vec_mask(mk0), .vec_pend(pd0));

    msi_cap_regs #(.CFG_AW(AW), .CAP_DW(BASE), .VEC_CAP(4), .ADDR64(1'b0), .MASK_EN(1'b0)) u_dut2 (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .pend_set(pend_set), .pend_clr(pend_clr),
        .msi_en(en1), .msg_mme(mme1), .msg_addr(ad1), .msg_data(dt1),
        .vec_mask(mk1), .vec_pend(pd1));

    // reference state per instance
    bit c64  [2] = '{1'b1, 1'b0};
    bit cmsk [2] = '{1'b1, 1'b0};
    int cvec [2] = '{8, 4};
    int clog [2] = '{3, 2};
    int cwin [2] = '{6, 3};

    logic        m_en   [2];
    logic [2:0]  m_mme  [2];
    logic [63:0] m_addr [2];
    logic [15:0] m_data [2];
    logic [31:0] m_mask [2];
    logic [31:0] m_pend [2];

    function automatic logic [31:0] vmask(int d);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < cvec[d]; i++) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] bmerge(logic [31:0] o, logic [31:0] w, logic [3:0] be, logic [31:0] wm);
        logic [31:0] r;
        r = o;
        for (int i = 0; i < 4; i++)
            if (be[i]) r[i*8 +: 8] = (w[i*8 +: 8] & wm[i*8 +: 8]) | (o[i*8 +: 8] & ~wm[i*8 +: 8]);
        return r;
    endfunction

    // kind: 0 none, 1 hdr, 2 addr lo, 3 addr hi, 4 data, 5 mask, 6 pending
    function automatic int kind(int d, int a);
        int rel;
        if (a < BASE || a >= BASE + cwin[d]) return 0;
        rel = a - BASE;
        if (rel == 0) return 1;
        if (rel == 1) return 2;
        if (c64[d]) return (rel == 2) ? 3 : (rel == 3) ? 4 : (rel == 4) ? 5 : 6;
        return (rel == 2) ? 4 : (rel == 3) ? 5 : 6;
    endfunction

    function automatic logic [31:0] exp_read(int d, int a);
        case (kind(d, a))
            1: return {7'h0, cmsk[d], c64[d], m_mme[d], 3'(clog[d]), m_en[d], 8'h00, 8'h05};
            2: return m_addr[d][31:0];
            3: return m_addr[d][63:32];
            4: return {16'h0, m_data[d]};
            5: return m_mask[d];
            6: return m_pend[d];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [191:0] exp_out(int d);
        return {44'h0, m_en[d], m_mme[d], m_addr[d], m_data[d], m_mask[d], m_pend[d]};
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_en[d] = 0; m_mme[d] = 0; m_addr[d] = 0; m_data[d] = 0; m_mask[d] = 0; m_pend[d] = 0;
        end
    endtask

    task automatic model_write(int a, logic [3:0] be, logic [31:0] w);
        logic [31:0] t;
        for (int d = 0; d < 2; d++) begin
            int k;
            k = kind(d, a);
            if (k != 0) begin
                case (k)
                    1: if (be[2]) begin m_en[d] = w[16]; m_mme[d] = w[22:20]; end
                    2: m_addr[d][31:0]  = bmerge(m_addr[d][31:0], w, be, 32'hFFFF_FFFC);
                    3: m_addr[d][63:32] = bmerge(m_addr[d][63:32], w, be, 32'hFFFF_FFFF);
                    4: begin t = bmerge({16'h0, m_data[d]}, w, be, 32'h0000_FFFF); m_data[d] = t[15:0]; end
                    5: m_mask[d] = bmerge(m_mask[d], w, be, vmask(d));
                    default: ;
                endcase
                if (m_en[d] && int'(m_mme[d]) > clog[d]) m_mme[d] = 3'(clog[d]);
            end
        end
    endtask

    task automatic chk(string tag, logic [191:0] act, logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_write(int a, logic [3:0] be, logic [31:0] w);
        @(negedge clk);
        cfg_addr = AW'(a); cfg_be = be; cfg_wdata = w; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_write(a, be, w);
    endtask

    task automatic pulse_pend(logic [31:0] s, logic [31:0] c);
        @(negedge clk);
        pend_set = s; pend_clr = c;
        @(negedge clk);
        pend_set = '0; pend_clr = '0;
        for (int d = 0; d < 2; d++)
            m_pend[d] = cmsk[d] ? (((m_pend[d] & ~c) | s) & vmask(d)) : 32'h0;
    endtask

    task automatic check_read(string tag, int a);
        @(negedge clk);
        cfg_addr = AW'(a);
        #1;
        chk({tag, " dut0 rd"}, {160'h0, rd0}, {160'h0, exp_read(0, a)});
        chk({tag, " dut1 rd"}, {160'h0, rd1}, {160'h0, exp_read(1, a)});
    endtask

    task automatic check_outs(string tag);
        @(negedge clk);
        #1;
        chk({tag, " dut0 out"}, {44'h0, en0, mme0, ad0, dt0, mk0, pd0}, exp_out(0));
        chk({tag, " dut1 out"}, {44'h0, en1, mme1, ad1, dt1, mk1, pd1}, exp_out(1));
    endtask

    task automatic read_all(string tag);
        for (int a = BASE - 1; a <= BASE + 6; a++) check_read(tag, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 header flags, R9 out-of-window reads
        read_all("R1 reset");
        check_outs("R1 reset outputs");

        // R2 read-only flags, R8 clamp on enabling write
        do_write(BASE, 4'hF, 32'hFFFF_FFFF);
        check_read("R2 ctrl all-ones", BASE);
        check_outs("R8 clamp on enable R11");

        // R8 oversized kept while disabled
        do_write(BASE, 4'b0100, 32'h0070_0000);
        check_read("R8 kept when disabled", BASE);
        do_write(BASE + 1, 4'hF, 32'h1234_5678);
        check_read("R8 kept after other write", BASE);
        do_write(BASE, 4'b0100, 32'h0071_0000);
        check_read("R8 clamp enable", BASE);
        do_write(BASE, 4'b0100, 32'h0011_0000);
        check_read("R8 legal value kept", BASE);
        // oversized write while enabled via byte 2 must clamp immediately
        do_write(BASE, 4'b0100, 32'h0061_0000);
        check_read("R8 clamp while enabled", BASE);

        // R3 address low bits
        do_write(BASE + 1, 4'hF, 32'hFFFF_FFFF);
        check_read("R3 addr lo", BASE + 1);
        // R4 / R5 dword +2
        do_write(BASE + 2, 4'hF, 32'hA5A5_1234);
        check_read("R4 hi or data", BASE + 2);
        // R5 data upper zero
        do_write(BASE + 3, 4'hF, 32'hFFFF_FFFF);
        check_read("R5 data width", BASE + 3);
        // R6 mask width
        do_write(BASE + 4, 4'hF, 32'hFFFF_FFFF);
        check_read("R6 mask bits", BASE + 4);
        // R10 byte enable
        do_write(BASE + 2, 4'b0100, 32'h00CC_0000);
        check_read("R10 byte enable", BASE + 2);
        check_outs("R11 exported values");

        // R7 pending
        pulse_pend(32'hFFFF_FFFF, 32'h0);
        check_read("R7 set", BASE + 5);
        do_write(BASE + 5, 4'hF, 32'h0);
        check_read("R7 sw write ignored", BASE + 5);
        pulse_pend(32'h0, 32'h0000_000F);
        check_read("R7 clear", BASE + 5);
        pulse_pend(32'h0000_0001, 32'h0000_0001);
        check_read("R7 set wins", BASE + 5);

        // R9 writes just outside window
        do_write(BASE - 1, 4'hF, 32'hFFFF_FFFF);
        do_write(BASE + 6, 4'hF, 32'hFFFF_FFFF);
        read_all("R9 outside ignored");
        check_outs("R9 outputs");

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        read_all("R1 second reset");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int a;
            logic [31:0] w;
            a = BASE - 2 + int'($urandom_range(0, 9));
            w = $urandom();
            if ($urandom_range(0, 3) == 0) w[22:20] = 3'($urandom_range(4, 7));
            do_write(a, 4'($urandom_range(0, 15)), w);
            if ($urandom_range(0, 4) == 0) pulse_pend($urandom(), $urandom());
            check_read("R10 random", a);
            check_read("R8 random ctrl", BASE);
            if (i % 20 == 0) check_outs("R11 random");
        end
        summary();
    end
endmodule